// File: doc/BRIEF.md
# Iterative Triple-DES Engine

This block encrypts or decrypts one 64-bit block with triple DES. It computes one DES round per clock, so the three 16-round passes take 48 cycles. All traffic passes through one 32-bit input and one 32-bit output. A small sequencer asks for key words with a single-cycle `givekey_o` strobe. It then takes the text block on a fixed schedule and flags the two result words with `ready_o`.

Each transaction follows the same order. Six key words come first: K1 high, K1 low, K2 high, K2 low, K3 high, K3 low. Each key word is requested by its own `givekey_o` pulse. The high text word and the mode bit follow in the next cycle, and the low text word in the cycle after that. One 64-bit state register carries the text through all three passes, with the initial permutation on entry and the final permutation on exit. When the result words have gone out, the next transaction starts at once.

Top module: `des3_core`

## Requirements
- R1: While `rst_ni` is low, `givekey_o` and `ready_o` are 0 and `data_o` is zero. The first rising clock edge after release raises `givekey_o`.
- R2: `givekey_o` is high for exactly one cycle per key word. The word on `data_i` is captured at the end of the cycle that follows the pulse. Six pulses occur per transaction. Words are taken in the order K1 high, K1 low, K2 high, K2 low, K3 high, K3 low.
- R3: The high text word is captured in the cycle after the last key word, and the low text word in the cycle after that. `decrypt_i` (1 = decrypt, 0 = encrypt) is sampled only together with the high text word. Its value in the low-word cycle has no effect.
- R4: `ready_o` rises on the 48th clock edge after the edge that captures the low text word. It stays high for exactly two cycles. The result's high 32 bits appear on `data_o` in the first cycle and the low 32 bits in the second.
- R5: `data_o` is all zero whenever `ready_o` is low.
- R6: Encryption computes E(K3, D(K2, E(K1, P))).
- R7: Decryption computes D(K1, E(K2, D(K3, C))).
- R8: Each pass is a standard 16-round DES. With K1 = K2 = K3 the result equals single DES. For key 133457799BBCDFF1 and plaintext 0123456789ABCDEF the result is 85E813540F0AB405. For key 0E329232EA6D0D73 and plaintext 8787878787878787 the result is 0000000000000000.
- R9: In the cycle after the second `ready_o` cycle, `givekey_o` is high and a new transaction begins.
- R10: `givekey_o` and `ready_o` are never high together.
- R11: Bit 0 of every key byte (the parity position) has no effect on the result.
- R12: Decrypting an encryption result with the same three keys returns the original plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| decrypt_i | input | 1 | Mode: 1 decrypt, 0 encrypt; sampled with the high text word |
| data_i | input | 32 | Key and text words |
| data_o | output | 32 | Result words while `ready_o` is high, zero otherwise |
| ready_o | output | 1 | Result word valid (two cycles) |
| givekey_o | output | 1 | Request strobe for the next key word |

## Verification
The assertions assume that reset is applied once before any traffic. They also assume that the environment presents every word exactly in the cycle the schedule reserves for it. The interface has no valid signal, so any other timing would scramble the keys rather than break a handshake rule. The bench waits for each `givekey_o` pulse at a falling edge, drives the word at once and holds it through the capture cycle. It then drives the two text words on the next two falling edges. It flips `decrypt_i` in the low-word cycle to show that the mode is sampled with the high word only.

// File: rtl/des3_pkg.sv
package des3_pkg;
  localparam int WORD_W    = 32;
  localparam int BLOCK_W   = 2 * WORD_W;
  localparam int KEY_W     = 56;
  localparam int HALF_W    = KEY_W / 2;
  localparam int SUB_W     = 48;
  localparam int ROUNDS    = 16;
  localparam int PASSES    = 3;
  localparam int KEY_WORDS = 2 * PASSES;
  localparam int RND_W     = $clog2(ROUNDS);
  localparam int PASS_W    = $clog2(PASSES);
  localparam int WIDX_W    = $clog2(KEY_WORDS);
  localparam int NBOX      = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KREQ, ST_KCAP, ST_THI, ST_TLO, ST_RUN, ST_OUT1, ST_OUT2
  } seq_st_e;

  localparam int PC1_T [56] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  localparam int PC2_T [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  localparam int PERM_T [32] = '{
    16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
     2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

  // rows 0..3 of each box, 16 nibbles per row, first column leftmost
  localparam logic [255:0] SBOX_T [NBOX] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D70934A6285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  // Source bit (1 = MSB) of initial-permutation output position i
  function automatic int ip_src(input int i);
    int r, c;
    r = i / 8;
    c = i % 8;
    return (r < 4) ? (58 + 2 * r - 8 * c) : (57 + 2 * (r - 4) - 8 * c);
  endfunction

  function automatic logic [BLOCK_W-1:0] ip_f(input logic [BLOCK_W-1:0] x);
    logic [BLOCK_W-1:0] y;
    for (int i = 0; i < BLOCK_W; i++) y[BLOCK_W-1-i] = x[BLOCK_W-ip_src(i)];
    return y;
  endfunction

  function automatic logic [BLOCK_W-1:0] fp_f(input logic [BLOCK_W-1:0] y);
    logic [BLOCK_W-1:0] x;
    for (int i = 0; i < BLOCK_W; i++) x[BLOCK_W-ip_src(i)] = y[BLOCK_W-1-i];
    return x;
  endfunction

  function automatic logic [KEY_W-1:0] pc1_f(input logic [BLOCK_W-1:0] k);
    logic [KEY_W-1:0] y;
    for (int i = 0; i < KEY_W; i++) y[KEY_W-1-i] = k[BLOCK_W-PC1_T[i]];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] pc2_f(input logic [KEY_W-1:0] cd);
    logic [SUB_W-1:0] y;
    for (int i = 0; i < SUB_W; i++) y[SUB_W-1-i] = cd[KEY_W-PC2_T[i]];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] expand_f(input logic [WORD_W-1:0] r);
    logic [SUB_W-1:0] e;
    int s;
    for (int j = 0; j < SUB_W; j++) begin
      s = 4 * (j / 6) + (j % 6);
      if (s == 0) s = WORD_W;
      if (s == WORD_W + 1) s = 1;
      e[SUB_W-1-j] = r[WORD_W-s];
    end
    return e;
  endfunction

  function automatic logic [WORD_W-1:0] perm_f(input logic [WORD_W-1:0] s);
    logic [WORD_W-1:0] p;
    for (int i = 0; i < WORD_W; i++) p[WORD_W-1-i] = s[WORD_W-PERM_T[i]];
    return p;
  endfunction

  // Schedule step idx (0-based) moves by two places except at 0, 1, 8, 15
  function automatic logic shift_two(input logic [RND_W-1:0] idx);
    return !(idx == 4'd0 || idx == 4'd1 || idx == 4'd8 || idx == 4'd15);
  endfunction

  function automatic logic [HALF_W-1:0] rot28(input logic [HALF_W-1:0] v,
                                              input logic left, input logic two);
    if (left) return two ? {v[HALF_W-3:0], v[HALF_W-1:HALF_W-2]} : {v[HALF_W-2:0], v[HALF_W-1]};
    else      return two ? {v[1:0], v[HALF_W-1:2]} : {v[0], v[HALF_W-1:1]};
  endfunction

  function automatic logic [KEY_W-1:0] cd_rot(input logic [KEY_W-1:0] cd,
                                              input logic left, input logic two);
    return {rot28(cd[KEY_W-1:HALF_W], left, two), rot28(cd[HALF_W-1:0], left, two)};
  endfunction
endpackage

// File: rtl/des3_sbox.sv
module des3_sbox
  import des3_pkg::*;
#(
  parameter int BOX = 0
) (
  input  logic [5:0] addr_i,
  output logic [3:0] dat_o
);
  localparam logic [255:0] TBL = SBOX_T[BOX];

  logic [5:0] idx;
  assign idx   = {addr_i[5], addr_i[0], addr_i[4:1]};
  assign dat_o = TBL[(63 - idx) * 4 +: 4];
endmodule

// File: rtl/des3_round.sv
module des3_round
  import des3_pkg::*;
(
  input  logic [BLOCK_W-1:0] st_i,
  input  logic [SUB_W-1:0]   subkey_i,
  input  logic               last_i,
  output logic [BLOCK_W-1:0] st_o
);
  logic [WORD_W-1:0] l_w, r_w, s_w, f_w, l_new;
  logic [SUB_W-1:0]  x_w;

  assign l_w = st_i[BLOCK_W-1:WORD_W];
  assign r_w = st_i[WORD_W-1:0];
  assign x_w = expand_f(r_w) ^ subkey_i;

  for (genvar g = 0; g < NBOX; g++) begin : g_box
    des3_sbox #(.BOX(g)) u_sbox (
      .addr_i (x_w[SUB_W-1-6*g -: 6]),
      .dat_o  (s_w[WORD_W-1-4*g -: 4])
    );
  end

  assign f_w   = perm_f(s_w);
  assign l_new = l_w ^ f_w;
  // halves stay in place after the last round of a pass
  assign st_o  = last_i ? {l_new, r_w} : {r_w, l_new};
endmodule

// File: rtl/des3_keysched.sv
module des3_keysched
  import des3_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             ld_dec_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             step_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic [SUB_W-1:0] subkey_o
);
  logic [KEY_W-1:0] kw_q;
  logic             dec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kw_q  <= '0;
      dec_q <= 1'b0;
    end else if (load_i) begin
      kw_q  <= ld_dec_i ? key_i : cd_rot(key_i, 1'b1, 1'b0);
      dec_q <= ld_dec_i;
    end else if (step_i) begin
      if (dec_q) kw_q <= cd_rot(kw_q, 1'b0, shift_two(4'd15 - rnd_i));
      else       kw_q <= cd_rot(kw_q, 1'b1, shift_two(rnd_i + 4'd1));
    end
  end

  assign subkey_o = pc2_f(kw_q);
endmodule

// File: rtl/des3_ctrl.sv
module des3_ctrl
  import des3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              givekey_o,
  output logic              ready_o,
  output logic              out_hi_o,
  output logic              key_cap_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic              text_hi_o,
  output logic              text_lo_o,
  output logic              run_o,
  output logic              last_o,
  output logic [RND_W-1:0]  rnd_o,
  output logic              key_load_o,
  output logic [PASS_W-1:0] ld_pass_o
);
  seq_st_e           st_q, st_d;
  logic [WIDX_W-1:0] widx_q;
  logic [RND_W-1:0]  rnd_q;
  logic [PASS_W-1:0] pass_q;
  logic              last_pass;

  assign last_pass = (pass_q == PASS_W'(PASSES - 1));
  assign last_o    = (rnd_q == RND_W'(ROUNDS - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: st_d = ST_KREQ;
      ST_KREQ: st_d = ST_KCAP;
      ST_KCAP: st_d = (widx_q == WIDX_W'(KEY_WORDS - 1)) ? ST_THI : ST_KREQ;
      ST_THI:  st_d = ST_TLO;
      ST_TLO:  st_d = ST_RUN;
      ST_RUN:  st_d = (last_o && last_pass) ? ST_OUT1 : ST_RUN;
      ST_OUT1: st_d = ST_OUT2;
      ST_OUT2: st_d = ST_KREQ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      widx_q <= '0;
      rnd_q  <= '0;
      pass_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_KCAP) widx_q <= widx_q + 1'b1;
      else if (st_q == ST_OUT2) widx_q <= '0;
      if (st_q == ST_TLO) begin
        rnd_q  <= '0;
        pass_q <= '0;
      end else if (st_q == ST_RUN) begin
        rnd_q <= rnd_q + 1'b1;
        if (last_o) pass_q <= pass_q + 1'b1;
      end
    end
  end

  assign givekey_o  = (st_q == ST_KREQ);
  assign ready_o    = (st_q == ST_OUT1) || (st_q == ST_OUT2);
  assign out_hi_o   = (st_q == ST_OUT1);
  assign key_cap_o  = (st_q == ST_KCAP);
  assign widx_o     = widx_q;
  assign text_hi_o  = (st_q == ST_THI);
  assign text_lo_o  = (st_q == ST_TLO);
  assign run_o      = (st_q == ST_RUN);
  assign rnd_o      = rnd_q;
  assign key_load_o = text_lo_o || (run_o && last_o && !last_pass);
  assign ld_pass_o  = text_lo_o ? '0 : pass_q + 1'b1;
endmodule

// File: rtl/des3_core.sv
module des3_core
  import des3_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        decrypt_i,
  input  logic [31:0] data_i,
  output logic [31:0] data_o,
  output logic        ready_o,
  output logic        givekey_o
);
  logic              out_hi, key_cap, text_hi, text_lo, run, last, key_load;
  logic [WIDX_W-1:0] widx;
  logic [RND_W-1:0]  rnd;
  logic [PASS_W-1:0] ld_pass, ld_idx;
  logic              ld_dec;

  logic [WORD_W-1:0]  hold_q;
  logic [KEY_W-1:0]   keys_q [PASSES];
  logic               dec_q;
  logic [BLOCK_W-1:0] text_q, text_nxt, res_w;
  logic [SUB_W-1:0]   subkey;

  des3_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .givekey_o  (givekey_o),
    .ready_o    (ready_o),
    .out_hi_o   (out_hi),
    .key_cap_o  (key_cap),
    .widx_o     (widx),
    .text_hi_o  (text_hi),
    .text_lo_o  (text_lo),
    .run_o      (run),
    .last_o     (last),
    .rnd_o      (rnd),
    .key_load_o (key_load),
    .ld_pass_o  (ld_pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      dec_q  <= 1'b0;
      text_q <= '0;
      for (int i = 0; i < PASSES; i++) keys_q[i] <= '0;
    end else begin
      if (key_cap) begin
        if (!widx[0]) hold_q <= data_i;
        else keys_q[widx[WIDX_W-1:1]] <= pc1_f({hold_q, data_i});
      end
      if (text_hi) begin
        hold_q <= data_i;
        dec_q  <= decrypt_i;
      end
      if (text_lo) text_q <= ip_f({hold_q, data_i});
      else if (run) text_q <= text_nxt;
    end
  end

  // decrypt runs the keys in reverse; the middle pass flips direction
  assign ld_idx = dec_q ? PASS_W'(PASSES - 1) - ld_pass : ld_pass;
  assign ld_dec = dec_q ^ (ld_pass == PASS_W'(1));

  des3_keysched u_ks (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (key_load),
    .ld_dec_i (ld_dec),
    .key_i    (keys_q[ld_idx]),
    .step_i   (run),
    .rnd_i    (rnd),
    .subkey_o (subkey)
  );

  des3_round u_round (
    .st_i     (text_q),
    .subkey_i (subkey),
    .last_i   (last),
    .st_o     (text_nxt)
  );

  assign res_w  = fp_f(text_q);
  assign data_o = !ready_o ? '0 : (out_hi ? res_w[BLOCK_W-1:WORD_W] : res_w[WORD_W-1:0]);
endmodule

// File: rtl/des3_core_chk.sv
module des3_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        givekey_o,
  input logic        ready_o,
  input logic [31:0] data_o
);
  a_r10_handshake_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(givekey_o && ready_o));

  a_r2_givekey_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    givekey_o |=> !givekey_o);

  a_r4_ready_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |=> ready_o);

  a_r4_ready_two_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |=> !ready_o);

  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (data_o == '0));

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> givekey_o);
endmodule

bind des3_core des3_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .givekey_o (givekey_o),
  .ready_o   (ready_o),
  .data_o    (data_o)
);

// File: tb/des3_core_tb.sv
`timescale 1ns/1ps
module des3_core_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        decrypt_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] data_o;
  logic        ready_o, givekey_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [63:0] KA  = 64'h133457799BBCDFF1;
  localparam logic [63:0] PA  = 64'h0123456789ABCDEF;
  localparam logic [63:0] CA  = 64'h85E813540F0AB405;
  localparam logic [63:0] KB  = 64'h0E329232EA6D0D73;
  localparam logic [63:0] PB  = 64'h8787878787878787;
  localparam logic [63:0] KX  = 64'hA1B2C3D4E5F60718;
  localparam logic [63:0] KY  = 64'h5566778899AABBCC;

  always #2.5 clk = ~clk;

  des3_core u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .decrypt_i (decrypt_i),
    .data_i    (data_i),
    .data_o    (data_o),
    .ready_o   (ready_o),
    .givekey_o (givekey_o)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One full transaction; R3 flips decrypt_i during the low text word
  task automatic run_txn(input logic [63:0] k1, input logic [63:0] k2, input logic [63:0] k3,
                         input logic [63:0] txt, input bit dec, output logic [63:0] res);
    logic [31:0] words [6];
    int lat;
    words = '{k1[63:32], k1[31:0], k2[63:32], k2[31:0], k3[63:32], k3[31:0]};
    for (int w = 0; w < 6; w++) begin
      lat = 0;
      while (!givekey_o && lat < 100) begin @(negedge clk); lat++; end
      data_i = words[w];
      @(negedge clk);
      chk(!givekey_o, "R2 pulse", {63'd0, givekey_o}, 64'd0);
    end
    @(negedge clk);
    data_i = txt[63:32];
    decrypt_i = dec;
    @(negedge clk);
    data_i = txt[31:0];
    decrypt_i = ~dec;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (!ready_o) chk(data_o == '0, "R5 quiet", {32'd0, data_o}, 64'd0);
    end while (!ready_o && lat < 100);
    chk(lat == 49, "R4 latency", 64'(lat), 64'd49);
    chk(!givekey_o, "R10 exclusive", {63'd0, givekey_o}, 64'd0);
    res[63:32] = data_o;
    @(negedge clk);
    chk(ready_o, "R4 second cycle", {63'd0, ready_o}, 64'd1);
    res[31:0] = data_o;
    @(negedge clk);
    chk(!ready_o, "R4 two cycles", {63'd0, ready_o}, 64'd0);
    chk(givekey_o, "R9 restart", {63'd0, givekey_o}, 64'd1);
    chk(data_o == '0, "R5 after", {32'd0, data_o}, 64'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!givekey_o && !ready_o && data_o == '0, "R1 reset",
        {30'd0, givekey_o, ready_o, data_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(givekey_o, "R1 first request", {63'd0, givekey_o}, 64'd1);
  endtask

  task automatic t_single_kat();
    logic [63:0] r;
    run_txn(KA, KA, KA, PA, 1'b0, r);
    chk(r == CA, "R8 R6 single vector A", r, CA);
    run_txn(KB, KB, KB, PB, 1'b0, r);
    chk(r == 64'd0, "R8 single vector B", r, 64'd0);
    run_txn(KA, KA, KA, CA, 1'b1, r);
    chk(r == PA, "R7 R3 single decrypt", r, PA);
  endtask

  task automatic t_key_order();
    logic [63:0] r;
    run_txn(KX, KX, KA, PA, 1'b0, r);
    chk(r == CA, "R6 third key last", r, CA);
    run_txn(KA, KY, KY, PA, 1'b0, r);
    chk(r == CA, "R6 first key first", r, CA);
    run_txn(KX, KX, KA, CA, 1'b1, r);
    chk(r == PA, "R7 third key first", r, PA);
    run_txn(KA, KY, KY, CA, 1'b1, r);
    chk(r == PA, "R7 first key last", r, PA);
  endtask

  task automatic t_parity();
    logic [63:0] r;
    logic [63:0] kp;
    kp = KA ^ 64'h0101010101010101;
    run_txn(kp, kp, kp, PA, 1'b0, r);
    chk(r == CA, "R11 parity ignored", r, CA);
  endtask

  task automatic t_roundtrip();
    logic [63:0] c, p;
    logic [63:0] pt;
    pt = 64'hFEDCBA9876543210;
    run_txn(KX, KY, KB, pt, 1'b0, c);
    chk(c != pt, "R12 cipher differs", c, pt);
    run_txn(KX, KY, KB, c, 1'b1, p);
    chk(p == pt, "R12 roundtrip", p, pt);
  endtask

  initial begin
    t_reset();
    t_single_kat();
    t_key_order();
    t_parity();
    t_roundtrip();
    finish_run();
  end
endmodule